// File: doc/BRIEF.md
# Three-Bus Register-Transfer Datapath

This block is a small processor datapath built around three internal buses. A register file with two read ports puts two source operands on buses A and B in the same cycle. An ALU combines them, and its result travels on bus C to the single write port. A mux in front of the ALU's A input can replace the bus-A operand with the constant 4.

The program counter has its own incrementer, so the ALU never advances it. A short control sequencer runs a four-phase loop for each instruction. It latches the program counter as the memory address, holds a read request until memory reports completion, moves the fetched word into the instruction register, and then executes. A register-to-register operation finishes in that one execute cycle.

The memory side is a plain request/complete handshake. The only visible effect of an instruction is a write strobe that carries the destination index and the bus-C value.

Top module: `tribus_core`

## Requirements
- R1: While reset is applied, and after it is released, `mem_rd` and `wr_en` are 0. The program counter restarts at address 0 and every register reads as zero.
- R2: During a fetch, `mem_rd` stays at 1 and `mem_addr` stays unchanged until the cycle in which `mem_done` is 1. The fetch takes as many cycles as memory needs.
- R3: The fetch addresses of consecutive instructions are 0, 4, 8, and so on. The program counter gains 4 once per completed fetch through its own incrementer, independently of the ALU.
- R4: Instruction bits [31:28] hold the opcode, [27:25] the destination index, [24:22] the bus-A source index and [21:19] the bus-B source index. All other bits are ignored.
- R5: Opcode 0 writes A+B, opcode 1 writes A-B and opcode 2 writes A XOR B, all modulo 2^32.
- R6: Opcode 3 writes operand A unchanged and opcode 4 writes operand B unchanged.
- R7: Opcode 5 selects the constant 4 on the ALU A input and writes 4+B.
- R8: When the destination is also a source, the operation reads the value the register held before this instruction.
- R9: Register 0 is written like every other register, and later reads return the written value.
- R10: Opcodes 6 to 15 write nothing. `wr_en` stays 0 for that instruction and the register contents are unchanged.
- R11: Each instruction pulses `wr_en` for exactly one cycle, two cycles after the cycle in which `mem_done` is seen. `wr_en` is never 1 while `mem_rd` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mem_addr | output | 32 | Fetch address, held from the address register |
| mem_rd | output | 1 | Read request, high for the whole fetch |
| mem_rdata | input | 32 | Instruction word, valid when mem_done is high |
| mem_done | input | 1 | Memory completion for the current read |
| wr_en | output | 1 | Register write strobe (bus C valid) |
| wr_idx | output | 3 | Destination register index |
| wr_data | output | 32 | Bus C value being written |

## Verification
A fixed program is fed from a bench-side memory model with fetch latencies of one to three cycles. Every write must match a hand-computed destination and value.

The opcodes are tried with operands that tell the operations apart:
- Add and subtract are run with operands whose difference wraps below zero, and XOR on a value with high bits set.
- The two pass modes are run with different A and B operands, so a swapped operand shows up.
- The constant-4 mode is run against a non-zero B operand.
- An instruction with the destination equal to both sources shows whether the old or the new value is read.
- An undefined opcode and a write to register 0 are followed by reads that would expose a stray or missing write.

A reset in mid-program, followed by a rerun of the first instructions, checks that the program counter and the registers return to zero.

// File: rtl/tribus_pkg.sv
package tribus_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD   = 4'd0,
    OP_SUB   = 4'd1,
    OP_XOR   = 4'd2,
    OP_PASSA = 4'd3,
    OP_PASSB = 4'd4,
    OP_ADD4  = 4'd5
  } op_e;

  typedef enum logic [1:0] {
    ALU_ADD  = 2'd0,
    ALU_SUB  = 2'd1,
    ALU_XOR  = 2'd2,
    ALU_PASS = 2'd3
  } alu_fn_e;

  typedef enum logic [1:0] {
    ST_ADDR = 2'd0,
    ST_WAIT = 2'd1,
    ST_LDIR = 2'd2,
    ST_EXEC = 2'd3
  } seq_st_e;
endpackage

// File: rtl/tribus_regfile.sv
module tribus_regfile #(
  parameter int XLEN = 32,
  parameter int NREG = 8,
  localparam int IDXW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [IDXW-1:0] rda_idx,
  input  logic [IDXW-1:0] rdb_idx,
  output logic [XLEN-1:0] rda_data,
  output logic [XLEN-1:0] rdb_data,
  input  logic            we,
  input  logic [IDXW-1:0] wi,
  input  logic [XLEN-1:0] wd
);
  logic [XLEN-1:0] regs_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic en;
    assign en = we && (wi == IDXW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  regs_q[g] <= '0;
      else if (en) regs_q[g] <= wd;
    end
  end

  assign rda_data = regs_q[rda_idx];
  assign rdb_data = regs_q[rdb_idx];

  // A write is visible on the read ports from the following cycle on (R8, R9).
  assert_write_visible_R8: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (rda_idx != $past(wi) || rda_data == $past(wd)));
  assert_write_visible_b_R9: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (rdb_idx != $past(wi) || rdb_data == $past(wd)));
endmodule

// File: rtl/tribus_alu.sv
module tribus_alu
  import tribus_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  alu_fn_e         fn,
  input  logic            pass_b,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] r
);
  always_comb begin
    case (fn)
      ALU_ADD: r = a + b;
      ALU_SUB: r = a - b;
      ALU_XOR: r = a ^ b;
      default: r = pass_b ? b : a;
    endcase
  end
endmodule

// File: rtl/tribus_seq.sv
module tribus_seq
  import tribus_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int STEP = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mem_done,
  input  logic [XLEN-1:0] mem_rdata,
  output logic [XLEN-1:0] mem_addr,
  output logic            mem_rd,
  output logic [XLEN-1:0] ir,
  output logic            exec
);
  localparam logic [XLEN-1:0] PC_STEP = XLEN'(STEP);

  seq_st_e         st_q, st_d;
  logic [XLEN-1:0] pc_q, mar_q, mdr_q, ir_q;
  logic            mar_en, fetch_end, ir_en;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_ADDR: st_d = ST_WAIT;
      ST_WAIT: if (mem_done) st_d = ST_LDIR;
      ST_LDIR: st_d = ST_EXEC;
      default: st_d = ST_ADDR;
    endcase
  end

  assign mar_en    = (st_q == ST_ADDR);
  assign fetch_end = (st_q == ST_WAIT) && mem_done;
  assign ir_en     = (st_q == ST_LDIR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_ADDR;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mar_q <= '0;
    else if (mar_en) mar_q <= pc_q;
  end

  // Dedicated incrementer: the ALU is never involved in advancing the PC.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;
      mdr_q <= '0;
    end else if (fetch_end) begin
      pc_q  <= pc_q + PC_STEP;
      mdr_q <= mem_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ir_q <= '0;
    else if (ir_en) ir_q <= mdr_q;
  end

  assign mem_addr = mar_q;
  assign mem_rd   = (st_q == ST_WAIT);
  assign ir       = ir_q;
  assign exec     = (st_q == ST_EXEC);

  assert_fetch_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && !mem_done) |=> (mem_rd && $stable(mem_addr)));
  assert_pc_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && mem_done) |=> (pc_q == $past(pc_q) + PC_STEP));
  assert_exec_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    exec |=> !exec);
endmodule

// File: rtl/tribus_core.sv
module tribus_core
  import tribus_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int NREG  = 8,
  parameter int CONST = 4,
  localparam int IDXW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [XLEN-1:0] mem_addr,
  output logic            mem_rd,
  input  logic [XLEN-1:0] mem_rdata,
  input  logic            mem_done,
  output logic            wr_en,
  output logic [IDXW-1:0] wr_idx,
  output logic [XLEN-1:0] wr_data
);
  localparam int OP_HI = XLEN - 1;
  localparam int RD_HI = OP_HI - OP_W;
  localparam int RA_HI = RD_HI - IDXW;
  localparam int RB_HI = RA_HI - IDXW;

  // Reset: asserted asynchronously, released through two flops.
  logic [1:0] rst_sync_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  logic [XLEN-1:0] ir, bus_a, bus_b, alu_a, bus_c;
  logic            exec;
  logic [OP_W-1:0] opc;
  logic [IDXW-1:0] rd_f, ra_f, rb_f;
  alu_fn_e         fn;
  logic            pass_b, sel_const, op_ok;

  tribus_seq #(.XLEN(XLEN), .STEP(4)) u_seq (
    .clk(clk), .rst_n(rst_i_n), .mem_done(mem_done), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .ir(ir), .exec(exec)
  );

  assign opc  = ir[OP_HI -: OP_W];
  assign rd_f = ir[RD_HI -: IDXW];
  assign ra_f = ir[RA_HI -: IDXW];
  assign rb_f = ir[RB_HI -: IDXW];

  always_comb begin
    fn        = ALU_PASS;
    pass_b    = 1'b0;
    sel_const = 1'b0;
    op_ok     = 1'b1;
    case (opc)
      OP_ADD:   fn = ALU_ADD;
      OP_SUB:   fn = ALU_SUB;
      OP_XOR:   fn = ALU_XOR;
      OP_PASSA: fn = ALU_PASS;
      OP_PASSB: pass_b = 1'b1;
      OP_ADD4: begin
        fn        = ALU_ADD;
        sel_const = 1'b1;
      end
      default:  op_ok = 1'b0;
    endcase
  end

  tribus_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
    .clk(clk), .rst_n(rst_i_n),
    .rda_idx(ra_f), .rdb_idx(rb_f), .rda_data(bus_a), .rdb_data(bus_b),
    .we(wr_en), .wi(rd_f), .wd(bus_c)
  );

  assign alu_a = sel_const ? XLEN'(CONST) : bus_a;

  tribus_alu #(.XLEN(XLEN)) u_alu (
    .fn(fn), .pass_b(pass_b), .a(alu_a), .b(bus_b), .r(bus_c)
  );

  assign wr_en   = exec && op_ok;
  assign wr_idx  = rd_f;
  assign wr_data = bus_c;

  assert_no_write_in_fetch_R11: assert property (@(posedge clk) disable iff (!rst_i_n)
    mem_rd |-> !wr_en);
  assert_write_after_done_R11: assert property (@(posedge clk) disable iff (!rst_i_n)
    wr_en |-> $past(mem_done, 2));
endmodule

// File: tb/tribus_core_bench.sv
`timescale 1ns/1ps
module tribus_core_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] mem_addr, mem_rdata, wr_data;
  logic        mem_rd, mem_done, wr_en;
  logic [2:0]  wr_idx;
  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  tribus_core u_tribus_core (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_rdata(mem_rdata), .mem_done(mem_done),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
  );

  // Fields: [31:28] opcode, [27:25] dest, [24:22] src A, [21:19] src B.
  localparam int N = 14;
  localparam logic [31:0] PROG [N] = '{
    32'h52000000, // r1 = 4 + r0            R7
    32'h54080000, // r2 = 4 + r1            R7
    32'h06500000, // r3 = r1 + r2           R5
    32'h18500000, // r4 = r1 - r2 (wraps)   R5
    32'h2B180000, // r5 = r4 ^ r3           R5
    32'h3D480000, // r6 = pass A (r5)       R6
    32'h4F500000, // r7 = pass B (r2)       R6
    32'h06D80000, // r3 = r3 + r3           R8
    32'hF6000000, // undefined opcode       R10
    32'h30C00000, // r0 = pass A (r3)       R9
    32'h52000000, // r1 = 4 + r0            R9
    32'h14000000, // r2 = r0 - r0           R9
    32'h09080000, // r4 = r4 + r1           R10 (r4 untouched by skip)
    32'h2DB00000  // r6 = r6 ^ r6           R8
  };
  localparam logic EXP_WE [N] = '{1,1,1,1,1,1,1,1,0,1,1,1,1,1};
  localparam logic [2:0] EXP_IDX [N] = '{1,2,3,4,5,6,7,3,3,0,1,2,4,6};
  localparam logic [31:0] EXP_VAL [N] = '{
    32'd4, 32'd8, 32'd12, 32'hFFFFFFFC, 32'hFFFFFFF0, 32'hFFFFFFF0, 32'd8,
    32'd24, 32'd0, 32'd24, 32'd28, 32'd0, 32'd24, 32'd0
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Serve one fetch at index k with lat extra wait cycles, then check the write.
  task automatic run_instr(input int k, input int lat);
    int n = 0;
    while (!mem_rd && n < 50) begin
      @(negedge clk);
      check(!wr_en || !mem_rd, "R11", 32'(wr_en), 32'd0);
      n++;
    end
    check(mem_rd, "R2", 32'(mem_rd), 32'd1);
    check(mem_addr == 32'(4 * k), "R3", mem_addr, 32'(4 * k));
    for (int i = 0; i < lat; i++) begin
      @(negedge clk);
      check(mem_rd && mem_addr == 32'(4 * k) && !wr_en, "R2",
            {31'd0, mem_rd}, 32'd1);
    end
    mem_rdata = PROG[k];
    mem_done  = 1'b1;
    @(negedge clk);
    mem_done  = 1'b0;
    mem_rdata = 32'hDEADBEEF;
    check(!mem_rd && !wr_en, "R11", 32'(wr_en), 32'd0);
    @(negedge clk);
    check(wr_en == EXP_WE[k], EXP_WE[k] ? "R11" : "R10", 32'(wr_en), 32'(EXP_WE[k]));
    if (EXP_WE[k]) begin
      check(wr_idx == EXP_IDX[k], "R4", 32'(wr_idx), 32'(EXP_IDX[k]));
      check(wr_data == EXP_VAL[k], "R5", wr_data, EXP_VAL[k]);
    end
    @(negedge clk);
    check(!wr_en, "R11", 32'(wr_en), 32'd0);
  endtask

  initial begin
    mem_done  = 1'b0;
    mem_rdata = '0;
    repeat (3) @(negedge clk);
    check(!mem_rd && !wr_en, "R1", {30'd0, mem_rd, wr_en}, 32'd0);
    rst_n = 1'b1;
    for (int k = 0; k < N; k++) run_instr(k, 1 + (k % 3));

    // Directed: reset in mid-program clears PC and registers (R1).
    repeat (2) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(!mem_rd && !wr_en, "R1", {30'd0, mem_rd, wr_en}, 32'd0);
    rst_n = 1'b1;
    run_instr(0, 0);   // r1 = 4 + r0 gives 4 again only if r0 was cleared
    run_instr(1, 2);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(8 * 100000);
    fails++;
    tests++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule